// File: doc/BRIEF.md
# Vector Register-Group Legality Checker

This block decides whether the vector register operands of one instruction are legal under register grouping, and supplies the address to report if they are not. A group spans 1, 2, 4 or 8 consecutive registers out of 32. The group size arrives as a 2-bit log2 code. The block applies up to three tests to the operands:

- The operand index must be aligned to the group size.
- The group must fit inside the register file.
- A mask-writing compare must not place its destination inside a multi-register source group.

Each test can be switched on or off on its own. The result is one illegal-instruction flag.

The block has no state. The flag and the fault address settle in the same cycle as the inputs. The fault address is the current program counter minus the 4-byte instruction length, so it points back at the instruction being checked. The decode stage supplies the operand indices, the group code taken from the vector configuration, and the check enables. It then uses the flag to raise a trap.

Top module: `vgl_legal_chk`

## Requirements
- R1: Group code `grp_code` values 0, 1, 2 and 3 select groups of 1, 2, 4 and 8 registers respectively.
- R2: With `en_align` high, an operand index that is not an exact multiple of the group size raises `illegal`.
- R3: With `en_bound` high, an operand index whose value plus the group size exceeds 32 raises `illegal`. A sum of exactly 32 is legal.
- R4: With `en_overlap` high, `mask_cmp` high and a group larger than 1, `illegal` is raised when `mask_dst` lies in the half-open range from `src_base` up to, but not including, `src_base` plus the group size. The range is computed without wrap-around at 32.
- R5: The overlap test never fires when the group size is 1 or when `mask_cmp` is low.
- R6: Each test is gated by its own enable. A disabled test has no effect on `illegal`, and with all three enables low `illegal` is 0.
- R7: `illegal` is the OR of the enabled tests. It is 1 if any enabled test fails, including when several fail in the same cycle, and 0 when all enabled tests pass.
- R8: `fault_pc` always equals `cur_pc` minus 4, modulo 2 to the power XLEN. It follows `cur_pc` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_align | input | 1 | Enable for the alignment test |
| en_bound | input | 1 | Enable for the register-file bound test |
| en_overlap | input | 1 | Enable for the mask-destination overlap test |
| mask_cmp | input | 1 | Instruction is a compare writing a mask register |
| grp_code | input | 2 | log2 of the register-group size |
| opnd_idx | input | 5 | Operand register index for the alignment and bound tests |
| mask_dst | input | 5 | Mask destination register index |
| src_base | input | 5 | First register of the compare's source group |
| cur_pc | input | XLEN | Current program counter |
| illegal | output | 1 | Illegal-instruction flag |
| fault_pc | output | XLEN | Address of the offending instruction |

## Verification
The alignment test and the overlap test can both fail on the same input vector, because they look at different operand fields. The bench applies one vector with a misaligned operand and a destination inside the source group. It then drops each enable in turn. With either failure enabled on its own, `illegal` must stay 1. It must fall to 0 only when both enables are low. This shows that the OR neither masks one cause with another nor depends on which cause arrived first.

// File: rtl/vgl_pkg.sv
package vgl_pkg;

    localparam int NUM_VREGS = 32;
    localparam int VIDX_W    = $clog2(NUM_VREGS);
    localparam int GCODE_W   = 2;
    localparam int SPAN_W    = VIDX_W + 1;

    typedef logic [VIDX_W-1:0] vidx_t;
    typedef logic [SPAN_W-1:0] span_t;

    typedef enum logic [GCODE_W-1:0] {
        GRP_X1 = 2'd0,
        GRP_X2 = 2'd1,
        GRP_X4 = 2'd2,
        GRP_X8 = 2'd3
    } grp_code_e;

    typedef struct packed {
        logic overlap;
        logic bound;
        logic align;
    } viol_t;

    function automatic span_t grp_regs(grp_code_e code);
        return span_t'(1) << code;
    endfunction

endpackage

// File: rtl/vgl_align_chk.sv
module vgl_align_chk
    import vgl_pkg::*;
(
    input  vidx_t     idx,
    input  grp_code_e code,
    output logic      bad
);
    span_t size;
    span_t low_mask;

    always_comb begin
        size     = grp_regs(code);
        low_mask = size - span_t'(1);
        bad      = (span_t'(idx) & low_mask) != '0;
    end
endmodule

// File: rtl/vgl_bound_chk.sv
module vgl_bound_chk
    import vgl_pkg::*;
(
    input  vidx_t     idx,
    input  grp_code_e code,
    output logic      bad
);
    localparam span_t LIMIT = span_t'(NUM_VREGS);

    span_t end_excl;

    always_comb begin
        end_excl = span_t'(idx) + grp_regs(code);
        bad      = end_excl > LIMIT;
    end
endmodule

// File: rtl/vgl_overlap_chk.sv
module vgl_overlap_chk
    import vgl_pkg::*;
(
    input  logic      mask_cmp,
    input  vidx_t     dst,
    input  vidx_t     src,
    input  grp_code_e code,
    output logic      bad
);
    span_t src_end;
    logic  multi;
    logic  in_range;

    always_comb begin
        src_end  = span_t'(src) + grp_regs(code);
        multi    = code != GRP_X1;
        in_range = (dst >= src) && (span_t'(dst) < src_end);
        bad      = mask_cmp && multi && in_range;
    end
endmodule

// File: rtl/vgl_fault_addr.sv
module vgl_fault_addr #(
    parameter int XLEN       = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] fault
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    assign fault = pc - STEP;
endmodule

// File: rtl/vgl_legal_chk.sv
module vgl_legal_chk
    import vgl_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic              en_align,
    input  logic              en_bound,
    input  logic              en_overlap,
    input  logic              mask_cmp,
    input  logic [1:0]        grp_code,
    input  logic [4:0]        opnd_idx,
    input  logic [4:0]        mask_dst,
    input  logic [4:0]        src_base,
    input  logic [XLEN-1:0]   cur_pc,
    output logic              illegal,
    output logic [XLEN-1:0]   fault_pc
);
    grp_code_e code;
    viol_t     viol;
    viol_t     enables;

    assign code    = grp_code_e'(grp_code);
    assign enables = '{overlap: en_overlap, bound: en_bound, align: en_align};

    vgl_align_chk u_align (
        .idx  (opnd_idx),
        .code (code),
        .bad  (viol.align)
    );

    vgl_bound_chk u_bound (
        .idx  (opnd_idx),
        .code (code),
        .bad  (viol.bound)
    );

    vgl_overlap_chk u_overlap (
        .mask_cmp (mask_cmp),
        .dst      (mask_dst),
        .src      (src_base),
        .code     (code),
        .bad      (viol.overlap)
    );

    vgl_fault_addr #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES)
    ) u_faddr (
        .pc    (cur_pc),
        .fault (fault_pc)
    );

    assign illegal = |(viol & enables);
endmodule

module vgl_legal_sva #(
    parameter int XLEN       = 64,
    parameter int INSN_BYTES = 4
) (
    input logic            en_align,
    input logic            en_bound,
    input logic            en_overlap,
    input logic            mask_cmp,
    input logic [1:0]      grp_code,
    input logic [4:0]      opnd_idx,
    input logic [4:0]      mask_dst,
    input logic [4:0]      src_base,
    input logic [XLEN-1:0] cur_pc,
    input logic            illegal,
    input logic [XLEN-1:0] fault_pc
);
    logic [5:0] sz;
    logic       known;

    always_comb begin
        sz    = 6'd1 << grp_code;
        known = !$isunknown({en_align, en_bound, en_overlap, mask_cmp, grp_code,
                             opnd_idx, mask_dst, src_base, cur_pc, illegal, fault_pc});
        if (known) begin
            AST_ALIGN_FAIL: assert (!(en_align && (opnd_idx % sz[4:0]) != 0) || illegal); // R2
            AST_BOUND_FAIL: assert (!(en_bound && ({1'b0, opnd_idx} + sz) > 6'd32) || illegal); // R3
            AST_OVERLAP_FAIL: assert (!(en_overlap && mask_cmp && grp_code != 2'd0 &&
                                        mask_dst >= src_base &&
                                        {1'b0, mask_dst} < ({1'b0, src_base} + sz)) || illegal); // R4
            AST_SINGLE_NO_OVL: assert (!(en_overlap && !en_align && !en_bound &&
                                         (grp_code == 2'd0 || !mask_cmp)) || !illegal); // R5
            AST_ALL_OFF: assert (en_align || en_bound || en_overlap || !illegal); // R6
            AST_FAULT_ADDR: assert (fault_pc + XLEN'(INSN_BYTES) == cur_pc); // R8
        end
    end
endmodule

bind vgl_legal_chk vgl_legal_sva #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES)
) u_sva (
    .en_align   (en_align),
    .en_bound   (en_bound),
    .en_overlap (en_overlap),
    .mask_cmp   (mask_cmp),
    .grp_code   (grp_code),
    .opnd_idx   (opnd_idx),
    .mask_dst   (mask_dst),
    .src_base   (src_base),
    .cur_pc     (cur_pc),
    .illegal    (illegal),
    .fault_pc   (fault_pc)
);

// File: tb/test_vgl_legal_chk.sv
module test_vgl_legal_chk;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            en_align, en_bound, en_overlap, mask_cmp;
    logic [1:0]      grp_code;
    logic [4:0]      opnd_idx, mask_dst, src_base;
    logic [XLEN-1:0] cur_pc;
    logic            illegal;
    logic [XLEN-1:0] fault_pc;

    vgl_legal_chk #(.XLEN(XLEN), .INSN_BYTES(4)) i_vgl_legal_chk (
        .en_align   (en_align),
        .en_bound   (en_bound),
        .en_overlap (en_overlap),
        .mask_cmp   (mask_cmp),
        .grp_code   (grp_code),
        .opnd_idx   (opnd_idx),
        .mask_dst   (mask_dst),
        .src_base   (src_base),
        .cur_pc     (cur_pc),
        .illegal    (illegal),
        .fault_pc   (fault_pc)
    );

    // en = {overlap, bound, align}
    typedef struct packed {
        logic [2:0] en;
        logic       mcmp;
        logic [1:0] gc;
        logic [4:0] idx;
        logic [4:0] dst;
        logic [4:0] src;
        logic       exp;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{3'b001, 1'b0, 2'd1, 5'd4,  5'd0,  5'd0,  1'b0}, // R1 R2 x2 aligned
        '{3'b001, 1'b0, 2'd2, 5'd6,  5'd0,  5'd0,  1'b1}, // R1 R2 x4 misaligned
        '{3'b001, 1'b0, 2'd3, 5'd24, 5'd0,  5'd0,  1'b0}, // R1 R2 x8 aligned
        '{3'b001, 1'b0, 2'd3, 5'd12, 5'd0,  5'd0,  1'b1}, // R1 R2 x8 misaligned
        '{3'b010, 1'b0, 2'd2, 5'd29, 5'd0,  5'd0,  1'b1}, // R3 sum 33
        '{3'b010, 1'b0, 2'd2, 5'd28, 5'd0,  5'd0,  1'b0}, // R3 sum 32
        '{3'b010, 1'b0, 2'd0, 5'd31, 5'd0,  5'd0,  1'b0}, // R3 last reg
        '{3'b100, 1'b1, 2'd2, 5'd0,  5'd9,  5'd8,  1'b1}, // R4 inside
        '{3'b100, 1'b1, 2'd2, 5'd0,  5'd12, 5'd8,  1'b0}, // R4 upper bound excluded
        '{3'b100, 1'b1, 2'd2, 5'd0,  5'd7,  5'd8,  1'b0}, // R4 below
        '{3'b100, 1'b1, 2'd0, 5'd0,  5'd8,  5'd8,  1'b0}, // R5 single reg
        '{3'b100, 1'b0, 2'd3, 5'd0,  5'd8,  5'd8,  1'b0}, // R5 not mask compare
        '{3'b000, 1'b1, 2'd2, 5'd6,  5'd9,  5'd8,  1'b0}, // R6 all off
        '{3'b111, 1'b1, 2'd3, 5'd8,  5'd0,  5'd16, 1'b0}, // R7 all pass
        '{3'b111, 1'b1, 2'd3, 5'd8,  5'd20, 5'd16, 1'b1}, // R7 overlap only
        '{3'b100, 1'b1, 2'd3, 5'd0,  5'd31, 5'd24, 1'b1}, // R4 top of file
        '{3'b100, 1'b1, 2'd3, 5'd0,  5'd2,  5'd28, 1'b0}  // R4 no wrap
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int cycles   = 0;

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    task automatic apply(input logic [2:0] en, input logic mc, input logic [1:0] gc,
                         input logic [4:0] idx, input logic [4:0] dst, input logic [4:0] src);
        @(posedge clk);
        #1;
        {en_overlap, en_bound, en_align} = en;
        mask_cmp = mc;
        grp_code = gc;
        opnd_idx = idx;
        mask_dst = dst;
        src_base = src;
        @(negedge clk);
    endtask

    task automatic chk_ill(input string req, input logic exp);
        n_checks++;
        if (illegal !== exp) begin
            n_fail++;
            $display("FAIL %s: illegal actual=%b expected=%b", req, illegal, exp);
        end
    endtask

    task automatic chk_pc(input logic [XLEN-1:0] exp);
        n_checks++;
        if (fault_pc !== exp) begin
            n_fail++;
            $display("FAIL R8: fault_pc actual=%h expected=%h", fault_pc, exp);
        end
    endtask

    initial begin
        cur_pc = 64'h0000_0000_8000_0010;
        // idle state: all enables low
        apply(3'b000, 1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
        chk_ill("R6 idle", 1'b0);
        chk_pc(64'h0000_0000_8000_000C);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].en, VECS[i].mcmp, VECS[i].gc, VECS[i].idx, VECS[i].dst, VECS[i].src);
            chk_ill($sformatf("vector %0d (R1..R7 table)", i), VECS[i].exp);
        end

        // R3 alone catches overflow that alignment would also catch
        apply(3'b010, 1'b0, 2'd1, 5'd31, 5'd0, 5'd0);
        chk_ill("R3 idx31 x2", 1'b1);

        // R7 coincident alignment and overlap failures, dropping enables in turn
        apply(3'b101, 1'b1, 2'd2, 5'd6, 5'd9, 5'd8);
        chk_ill("R7 both fail", 1'b1);
        apply(3'b001, 1'b1, 2'd2, 5'd6, 5'd9, 5'd8);
        chk_ill("R7 align only", 1'b1);
        apply(3'b100, 1'b1, 2'd2, 5'd6, 5'd9, 5'd8);
        chk_ill("R7 overlap only", 1'b1);
        apply(3'b000, 1'b1, 2'd2, 5'd6, 5'd9, 5'd8);
        chk_ill("R6 both disabled", 1'b0);
        apply(3'b010, 1'b1, 2'd2, 5'd6, 5'd9, 5'd8);
        chk_ill("R6 bound only passes", 1'b0);

        // R8 fault address including wrap
        @(posedge clk); #1 cur_pc = 64'h0000_0000_0000_1000;
        @(negedge clk); chk_pc(64'h0000_0000_0000_0FFC);
        @(posedge clk); #1 cur_pc = 64'h0000_0000_0000_0002;
        @(negedge clk); chk_pc(64'hFFFF_FFFF_FFFF_FFFE);
        @(posedge clk); #1 cur_pc = 64'h0;
        @(negedge clk); chk_pc(64'hFFFF_FFFF_FFFF_FFFC);

        done = 1'b1;
        report();
    end
endmodule